// File: doc/BRIEF.md
# Page address translation register file

This block is a small memory-management unit for an 8-bit processor with a 16-bit address bus. The logical space is cut into sixteen 4 KB pages. Each page owns one 8-bit translation entry. The processor's top four address bits select the page. The block returns that page's entry as the high-order bits of the physical address. The system keeps the low seven of those bits and places them above logical address bits 11:1. This forms an 18-bit word address into a 16-bit-wide RAM, which gives about 512 KB of reachable space.

Software loads the entries through a clocked write port. The port uses a chip select, a read/write flag, a data byte and a 4-bit entry index, where the index is logical address bits 3:0. The entries live in the top sixteen bytes of the logical space, and reads there are served by other memory, so the entries cannot be read back. On the lookup path, the high nibble of an entry passes through unchanged and the low nibble comes out inverted. A translated low nibble of all ones marks the monitor page and `1110` marks the I/O page. After reset, every page maps to itself, so the I/O and monitor pages can be reached before any entry is programmed.

Top module: `page_xlate`

## Requirements
- R1: After a synchronous reset, and before any write, `physHigh` equals `pageIndex` zero-extended to 8 bits for each of the sixteen pages.
- R2: On a rising clock edge with `sel`=1 and `rdNotWr`=0, the entry numbered `wrIndex` captures `wrData`.
- R3: `physHigh` is the entry chosen by `pageIndex`, with bits 7:4 passed through and bits 3:0 inverted.
- R4: A cycle with `sel`=0, or with `sel`=1 and `rdNotWr`=1, changes no entry.
- R5: A write changes only the entry chosen by `wrIndex`. All other fifteen lookups are unchanged.
- R6: In the cycle of a write, a lookup of the entry being written returns its old value. The new value appears from the next cycle on.
- R7: The lookup is combinational. A change of `pageIndex` changes `physHigh` in the same cycle, without a clock edge.
- R8: Writing a byte whose low nibble is 0000 makes the page translate to low nibble 1111 (monitor page). A low nibble of 0001 translates to 1110 (I/O page).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; writes are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the identity mapping |
| sel | input | 1 | Chip select for the write port |
| rdNotWr | input | 1 | 1 = read cycle (ignored), 0 = write cycle |
| wrIndex | input | 4 | Entry to load (logical address bits 3:0) |
| wrData | input | 8 | Byte to store |
| pageIndex | input | 4 | Logical page being looked up (address bits 15:12) |
| physHigh | output | 8 | Translated high physical address bits |

## Verification
A write and a lookup of the same entry can fall in one cycle. This is the interesting overlap, because the lookup is combinational while the write lands only on the clock edge. The bench provokes it by setting `pageIndex` equal to `wrIndex` while the write is driven. It samples `physHigh` once before the capturing edge and expects the old translated value. It samples again after that edge and expects the new one. The expected values come from a bench-side model that applies the nibble inversion arithmetically.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  localparam int PAGE_BITS = 4;
  localparam int PAGES     = 1 << PAGE_BITS;

  // Strobes from the write decoder to the register datapath
  typedef struct packed {
    logic                 load;
    logic [PAGE_BITS-1:0] index;
  } xlateStrobe_t;
endpackage

// File: rtl/page_xlate_ctrl.sv
module page_xlate_ctrl
  import page_xlate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 rdNotWr,
  input  logic [PAGE_BITS-1:0] wrIndex,
  output xlateStrobe_t         stb
);
  always_comb begin
    stb.load  = sel & ~rdNotWr;
    stb.index = wrIndex;
  end

  AST_NO_LOAD_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (rdNotWr || !sel) |-> !stb.load); // R4
  AST_INDEX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    stb.load |-> (stb.index == wrIndex)); // R2
endmodule

// File: rtl/page_xlate_dp.sv
module page_xlate_dp
  import page_xlate_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter int FLIP_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  xlateStrobe_t         stb,
  input  logic [ENTRY_W-1:0]   wrData,
  input  logic [PAGE_BITS-1:0] pageIndex,
  output logic [ENTRY_W-1:0]   physHigh
);
  localparam logic [ENTRY_W-1:0] FLIP_MASK = ENTRY_W'((1 << FLIP_W) - 1);

  logic [ENTRY_W-1:0] rows [PAGES];

  for (genvar r = 0; r < PAGES; r++) begin : g_row
    // Stored raw; reset so the flipped output equals the page number
    localparam logic [ENTRY_W-1:0] RESET_RAW = ENTRY_W'(r) ^ FLIP_MASK;
    always_ff @(posedge clk) begin
      if (rst) begin
        rows[r] <= RESET_RAW;
      end else if (stb.load && (stb.index == PAGE_BITS'(r))) begin
        rows[r] <= wrData;
      end
    end
  end

  always_comb begin
    physHigh = rows[pageIndex] ^ FLIP_MASK;
  end

  AST_RESET_IDENTITY: assert property (@(posedge clk)
    rst |=> (physHigh == ENTRY_W'(pageIndex))); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> ((pageIndex == $past(stb.index)) ->
      (physHigh == ($past(wrData) ^ FLIP_MASK)))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> ($stable(pageIndex) -> $stable(physHigh))); // R4
  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> (($stable(pageIndex) && (pageIndex != $past(stb.index))) ->
      $stable(physHigh))); // R5
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter int FLIP_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 rdNotWr,
  input  logic [PAGE_BITS-1:0] wrIndex,
  input  logic [ENTRY_W-1:0]   wrData,
  input  logic [PAGE_BITS-1:0] pageIndex,
  output logic [ENTRY_W-1:0]   physHigh
);
  xlateStrobe_t stb;

  page_xlate_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sel(sel), .rdNotWr(rdNotWr),
    .wrIndex(wrIndex), .stb(stb)
  );

  page_xlate_dp #(.ENTRY_W(ENTRY_W), .FLIP_W(FLIP_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData),
    .pageIndex(pageIndex), .physHigh(physHigh)
  );
endmodule

// File: tb/page_xlate_bench.sv
module page_xlate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0;
  logic       rdNotWr = 1'b1;
  logic [3:0] wrIndex = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic [3:0] pageIndex = 4'd0;
  logic [7:0] physHigh;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  page_xlate u_page_xlate (
    .clk(clk), .rst(rst), .sel(sel), .rdNotWr(rdNotWr), .wrIndex(wrIndex),
    .wrData(wrData), .pageIndex(pageIndex), .physHigh(physHigh)
  );

  function automatic logic [7:0] xl(input logic [7:0] raw);
    return {raw[7:4], ~raw[3:0]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s page %0d actual %02h expected %02h", req, pageIndex, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int p = 0; p < 16; p++) begin
      pageIndex = 4'(p);
      #1;
      check(req, physHigh, xl(model[p]));
    end
  endtask

  task automatic busCycle(input logic s, input logic rd, input logic [3:0] idx,
                          input logic [7:0] d);
    @(negedge clk);
    sel = s; rdNotWr = rd; wrIndex = idx; wrData = d;
    @(negedge clk);
    sel = 1'b0; rdNotWr = 1'b1;
    if (s && !rd) model[idx] = d;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 16; p++) model[p] = 8'(p) ^ 8'h0F;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 identity after reset
    checkAll("R1");

    // R2 R3 R5: write each entry, recheck all sixteen lookups each time
    for (int i = 0; i < 16; i++) begin
      busCycle(1'b1, 1'b0, 4'(i), 8'((i * 37 + 5) & 8'hFF));
      checkAll("R2_R3_R5");
    end

    // R4: read cycles and deselected writes change nothing
    for (int i = 0; i < 16; i++) begin
      busCycle(1'b1, 1'b1, 4'(i), 8'hA5 ^ 8'(i));
      busCycle(1'b0, 1'b0, 4'(i), 8'h3C ^ 8'(i));
    end
    checkAll("R4");

    // R6: same-cycle lookup sees old value, next cycle sees new
    for (int i = 0; i < 16; i += 5) begin
      @(negedge clk);
      pageIndex = 4'(i);
      sel = 1'b1; rdNotWr = 1'b0; wrIndex = 4'(i); wrData = 8'(8'hC0 + i);
      #1;
      check("R6_old", physHigh, xl(model[i]));
      @(negedge clk);
      sel = 1'b0; rdNotWr = 1'b1;
      model[i] = 8'(8'hC0 + i);
      #1;
      check("R6_new", physHigh, xl(model[i]));
    end

    // R7: lookup follows pageIndex with no clock edge
    @(negedge clk);
    pageIndex = 4'd3;
    #1;
    check("R7", physHigh, xl(model[3]));
    pageIndex = 4'd12;
    #1;
    check("R7", physHigh, xl(model[12]));

    // R8: monitor and I/O page encodings
    busCycle(1'b1, 1'b0, 4'd2, 8'h70);
    busCycle(1'b1, 1'b0, 4'd9, 8'h41);
    pageIndex = 4'd2;
    #1;
    check("R8_mon", physHigh, 8'h7F);
    pageIndex = 4'd9;
    #1;
    check("R8_io", physHigh, 8'h4E);
    checkAll("R8_R5");

    // R1 again: reset restores identity after programming
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < 16; p++) model[p] = 8'(p) ^ 8'h0F;
    checkAll("R1_rerun");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule